// File: doc/BRIEF.md
# I2C Ten-Bit-Address Slave Receiver

This block is a write-only I2C slave that answers to a programmable 10-bit address. It samples SCL and SDA with the system clock and finds START, repeated START and STOP conditions. It checks the two-byte 10-bit address header, then shifts in the data bytes of the write transfer. Each completed byte goes to a host-side data register. SDA is driven only through an open-drain enable, and this block never stretches SCL.

The host reacts to two flags. A receive-full flag is raised for every data byte, and a stop-event flag is raised when an addressed transfer ends. Either flag raises the interrupt line. When the host can take only one more byte, it arms a NAK-next control. The next data byte is then still captured, but it is refused on the bus. After that the slave stays off the bus until the next START or STOP. With general call enabled, a first byte of 0x00 is also accepted, and the bytes after it are taken as data.

The system clock must run at least 8x faster than SCL.

Top module: `i2c10_slave_rx`

## Requirements
- R1: The first byte after a START is acknowledged only if it equals {5'b11110, own_addr_i[9:8], 1'b0}. A set direction bit (bit 0 = 1) or any other mismatch is answered with NAK, and the slave ignores the bus until the next START.
- R2: The second address byte is acknowledged only if it equals own_addr_i[7:0]. On a mismatch the slave sends NAK and ignores the bus until the next START.
- R3: An ACK is given by holding sda_oe_o = 1 (SDA pulled low) through the ninth SCL clock of the byte. A NAK leaves sda_oe_o = 0.
- R4: sda_oe_o becomes asserted only while the synchronised SCL is low.
- R5: After each data byte (received MSB first), rx_data_o holds the byte, rx_full_o is 1 and irq_o is 1.
- R6: A data_rd_i pulse clears rx_full_o. irq_o then falls if stop_evt_o is 0.
- R7: A STOP after a full address match sets stop_evt_o and irq_o. A stat_rd_i pulse clears stop_evt_o.
- R8: A repeated START after a full address match sets stop_evt_o and begins a new address phase.
- R9: A START or STOP while the slave is not addressed leaves stop_evt_o at 0.
- R10: A nak_set_i pulse sets nak_next_o. The next data byte is stored and flagged in rx_full_o but refused with NAK, and nak_next_o clears. Later bytes are not acknowledged and do not change rx_data_o or rx_full_o until a START or STOP. The transfer's STOP still sets stop_evt_o.
- R11: With gc_en_i = 1, a first byte of 0x00 is acknowledged and the bytes after it are received as data. With gc_en_i = 0 that byte gets NAK.
- R12: With en_i = 0 the slave never drives SDA and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| en_i | input | 1 | Slave enable |
| gc_en_i | input | 1 | General-call enable |
| own_addr_i | input | 10 | Own 10-bit address |
| nak_set_i | input | 1 | Pulse: refuse the next data byte |
| data_rd_i | input | 1 | Pulse: host read of the data register |
| stat_rd_i | input | 1 | Pulse: host read of the status register |
| rx_data_o | output | 8 | Last received data byte |
| rx_full_o | output | 1 | Receive-data-full flag |
| stop_evt_o | output | 1 | Stop / repeated-START event flag |
| nak_next_o | output | 1 | NAK-next control state |
| irq_o | output | 1 | Interrupt: rx_full_o or stop_evt_o |

## Verification
A wrong address-phase state shows at the ninth SCL clock of the affected byte, as a missing or extra ACK, and so it is seen within one byte time. A bit counter that is out of step shows a wrong rx_data_o value, or an ACK on the wrong clock, at the end of the first data byte. A bad addressed state shows at the next STOP or repeated START: stop_evt_o is set when it should stay clear, or the reverse. A NAK-next control that is mishandled shows as an ACK on the refused byte, or as data that keeps arriving after the refusal.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_DATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/i2c10_bus_sync.sv
module i2c10_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_q  <= scl_sr[STAGES-1];
      sda_q  <= sda_sr[STAGES-1];
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c10_rx_fsm.sv
module i2c10_rx_fsm
  import i2c10_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              gc_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              nak_next_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_oe_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              nak_taken_o,
  output logic              end_evt_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  phase_e            phase_q, phase_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              addressed_q, sda_oe_q;
  logic              ack_nx, addr_set_nx, done_nx, nak_nx;

  // decision at the end of a byte
  always_comb begin
    ack_nx      = 1'b0;
    addr_set_nx = 1'b0;
    done_nx     = 1'b0;
    nak_nx      = 1'b0;
    phase_nx    = PH_SKIP;
    unique case (phase_q)
      PH_ADDR_HI: begin
        if (shreg_q == {TEN_BIT_PREFIX, own_addr_i[9:8], 1'b0}) begin
          ack_nx   = 1'b1;
          phase_nx = PH_ADDR_LO;
        end else if (gc_en_i && shreg_q == '0) begin
          ack_nx      = 1'b1;
          addr_set_nx = 1'b1;
          phase_nx    = PH_DATA;
        end
      end
      PH_ADDR_LO: begin
        if (shreg_q == own_addr_i[7:0]) begin
          ack_nx      = 1'b1;
          addr_set_nx = 1'b1;
          phase_nx    = PH_DATA;
        end
      end
      PH_DATA: begin
        done_nx = 1'b1;
        if (nak_next_i) begin
          nak_nx = 1'b1;
        end else begin
          ack_nx   = 1'b1;
          phase_nx = PH_DATA;
        end
      end
      default: ;
    endcase
  end

  wire active = (phase_q == PH_ADDR_HI) || (phase_q == PH_ADDR_LO) || (phase_q == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      shreg_q     <= '0;
      addressed_q <= 1'b0;
      sda_oe_q    <= 1'b0;
      byte_done_o <= 1'b0;
      nak_taken_o <= 1'b0;
      end_evt_o   <= 1'b0;
    end else begin
      byte_done_o <= 1'b0;
      nak_taken_o <= 1'b0;
      end_evt_o   <= 1'b0;
      if (!en_i) begin
        phase_q     <= PH_IDLE;
        cnt_q       <= '0;
        addressed_q <= 1'b0;
        sda_oe_q    <= 1'b0;
      end else if (start_i || stop_i) begin
        end_evt_o   <= addressed_q;
        addressed_q <= 1'b0;
        sda_oe_q    <= 1'b0;
        cnt_q       <= '0;
        phase_q     <= start_i ? PH_ADDR_HI : PH_IDLE;
      end else if (scl_fall_i && cnt_q == ACK_BIT) begin
        sda_oe_q <= 1'b0;
        cnt_q    <= '0;
      end else if (active && scl_fall_i && cnt_q == LAST_BIT) begin
        cnt_q       <= ACK_BIT;
        sda_oe_q    <= ack_nx;
        phase_q     <= phase_nx;
        byte_done_o <= done_nx;
        nak_taken_o <= nak_nx;
        if (addr_set_nx) addressed_q <= 1'b1;
      end else if (active && scl_rise_i && cnt_q < LAST_BIT) begin
        shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign sda_oe_o = sda_oe_q;
  assign byte_o   = shreg_q;

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_q && !$past(sda_oe_q)) |-> !$past(scl_i)); // R4
  AST_NAK_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_taken_o |-> (!sda_oe_q && phase_q == PH_SKIP)); // R10
  AST_DATA_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> addressed_q); // R5
  AST_NO_DRIVE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !sda_oe_q); // R12
endmodule

// File: rtl/i2c10_host_regs.sv
module i2c10_host_regs
  import i2c10_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              nak_taken_i,
  input  logic              end_evt_i,
  input  logic              nak_set_i,
  input  logic              data_rd_i,
  input  logic              stat_rd_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              stop_evt_o,
  output logic              nak_next_o,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o  <= '0;
      rx_full_o  <= 1'b0;
      stop_evt_o <= 1'b0;
      nak_next_o <= 1'b0;
    end else begin
      if (byte_done_i) begin
        rx_data_o <= byte_i;
        rx_full_o <= 1'b1;
      end else if (data_rd_i) begin
        rx_full_o <= 1'b0;
      end
      if (end_evt_i)      stop_evt_o <= 1'b1;
      else if (stat_rd_i) stop_evt_o <= 1'b0;
      if (nak_set_i)        nak_next_o <= 1'b1;
      else if (nak_taken_i) nak_next_o <= 1'b0;
    end
  end

  assign irq_o = rx_full_o | stop_evt_o;

  AST_FULL_ON_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i |=> (rx_full_o && irq_o)); // R5
  AST_STOP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_evt_i |=> stop_evt_o); // R7
  AST_NAK_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nak_taken_i && !nak_set_i) |=> !nak_next_o); // R10
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && !byte_done_i) |=> !rx_full_o); // R6
endmodule

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx
  import i2c10_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              en_i,
  input  logic              gc_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              nak_set_i,
  input  logic              data_rd_i,
  input  logic              stat_rd_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              stop_evt_o,
  output logic              nak_next_o,
  output logic              irq_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic byte_done, nak_taken, end_evt;
  logic [BYTE_W-1:0] byte_w;

  i2c10_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2c10_rx_fsm i_fsm (
    .clk_i, .rst_ni, .en_i, .gc_en_i, .own_addr_i,
    .nak_next_i(nak_next_o), .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_c), .stop_i(stop_c),
    .sda_oe_o, .byte_done_o(byte_done), .byte_o(byte_w),
    .nak_taken_o(nak_taken), .end_evt_o(end_evt)
  );

  i2c10_host_regs i_regs (
    .clk_i, .rst_ni, .byte_done_i(byte_done), .byte_i(byte_w),
    .nak_taken_i(nak_taken), .end_evt_i(end_evt), .nak_set_i, .data_rd_i, .stat_rd_i,
    .rx_data_o, .rx_full_o, .stop_evt_o, .nak_next_o, .irq_o
  );
endmodule

// File: tb/test_i2c10_slave_rx.sv
module test_i2c10_slave_rx;
  localparam int Q = 20;
  localparam logic [9:0] OWN = 10'h2A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, en = 1'b1, gc_en = 1'b0;
  logic [9:0] own = OWN;
  logic nak_set = 1'b0, data_rd = 1'b0, stat_rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, stop_evt, nak_next, irq;
  logic sda_line;
  int n_chk = 0, n_fail = 0;

  assign sda_line = sda_m & ~sda_oe;
  always #2.5 clk = ~clk;

  i2c10_slave_rx i_i2c10_slave_rx (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .en_i(en), .gc_en_i(gc_en), .own_addr_i(own), .nak_set_i(nak_set),
    .data_rd_i(data_rd), .stat_rd_i(stat_rd), .rx_data_o(rx_data), .rx_full_o(rx_full),
    .stop_evt_o(stop_evt), .nak_next_o(nak_next), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      wq(); sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
    end
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = ~sda_line;
    wq(); scl_m = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
  endtask

  task automatic address(output logic a1, output logic a2);
    bus_start();
    send_byte({5'b11110, OWN[9:8], 1'b0}, a1);
    send_byte(OWN[7:0], a2);
  endtask

  task automatic t_reset();
    chk("R5 reset rx_full", rx_full, 0);
    chk("R7 reset stop_evt", stop_evt, 0);
    chk("R6 reset irq", irq, 0);
    chk("R3 reset sda_oe", sda_oe, 0);
    chk("R10 reset nak_next", nak_next, 0);
  endtask

  task automatic t_basic_write();
    logic a1, a2, a;
    address(a1, a2);
    chk("R1 first byte ack", a1, 1);
    chk("R2 second byte ack", a2, 1);
    send_byte(8'h3C, a);
    chk("R3 data ack", a, 1);
    chk("R5 data value", rx_data, 8'h3C);
    chk("R5 rx_full", rx_full, 1);
    chk("R5 irq", irq, 1);
    pulse(data_rd);
    chk("R6 rx_full cleared", rx_full, 0);
    chk("R6 irq low", irq, 0);
    send_byte(8'hC3, a);
    chk("R5 second data", rx_data, 8'hC3);
    pulse(data_rd);
    chk("R7 no event before stop", stop_evt, 0);
    bus_stop();
    chk("R7 stop event", stop_evt, 1);
    chk("R7 irq on stop", irq, 1);
    pulse(stat_rd);
    chk("R7 stop cleared", stop_evt, 0);
  endtask

  task automatic t_bad_hi();
    logic a;
    bus_start();
    send_byte({5'b11110, ~OWN[9:8], 1'b0}, a);
    chk("R1 wrong high bits nak", a, 0);
    send_byte(OWN[7:0], a);
    chk("R1 ignored until start", a, 0);
    send_byte(8'h77, a);
    chk("R1 no data taken", rx_full, 0);
    bus_stop();
    chk("R9 stop while unaddressed", stop_evt, 0);
    bus_start();
    send_byte({5'b11110, OWN[9:8], 1'b1}, a);
    chk("R1 read direction nak", a, 0);
    bus_stop();
    chk("R9 no event", stop_evt, 0);
  endtask

  task automatic t_bad_lo();
    logic a;
    bus_start();
    send_byte({5'b11110, OWN[9:8], 1'b0}, a);
    chk("R1 first byte ack", a, 1);
    send_byte(~OWN[7:0], a);
    chk("R2 low byte mismatch nak", a, 0);
    send_byte(8'h11, a);
    chk("R2 ignored after mismatch", a, 0);
    chk("R2 no data", rx_full, 0);
    bus_stop();
    chk("R9 no event after partial", stop_evt, 0);
  endtask

  task automatic t_nak_ctrl();
    logic a1, a2, a;
    address(a1, a2);
    pulse(nak_set);
    chk("R10 nak_next set", nak_next, 1);
    send_byte(8'h5A, a);
    chk("R10 refused byte nak", a, 0);
    chk("R10 byte stored", rx_data, 8'h5A);
    chk("R10 byte flagged", rx_full, 1);
    chk("R10 nak self-clear", nak_next, 0);
    pulse(data_rd);
    send_byte(8'h99, a);
    chk("R10 later byte not acked", a, 0);
    chk("R10 later byte not stored", rx_data, 8'h5A);
    chk("R10 later byte not flagged", rx_full, 0);
    bus_stop();
    chk("R10 stop event after nak", stop_evt, 1);
    pulse(stat_rd);
  endtask

  task automatic t_restart();
    logic a1, a2, a;
    address(a1, a2);
    send_byte(8'h42, a);
    pulse(data_rd);
    bus_start();
    chk("R8 restart sets event", stop_evt, 1);
    pulse(stat_rd);
    send_byte({5'b11110, OWN[9:8], 1'b0}, a1);
    send_byte(OWN[7:0], a2);
    chk("R8 readdress after restart", {a1, a2}, 2'b11);
    send_byte(8'hE7, a);
    chk("R8 data after restart", rx_data, 8'hE7);
    pulse(data_rd);
    bus_stop();
    chk("R7 stop after restart", stop_evt, 1);
    pulse(stat_rd);
  endtask

  task automatic t_general_call();
    logic a;
    bus_start();
    send_byte(8'h00, a);
    chk("R11 gc disabled nak", a, 0);
    bus_stop();
    gc_en = 1'b1;
    bus_start();
    send_byte(8'h00, a);
    chk("R11 gc ack", a, 1);
    send_byte(8'h81, a);
    chk("R11 gc data ack", a, 1);
    chk("R11 gc data", rx_data, 8'h81);
    pulse(data_rd);
    bus_stop();
    chk("R11 gc stop event", stop_evt, 1);
    pulse(stat_rd);
    gc_en = 1'b0;
  endtask

  task automatic t_disabled();
    logic a1, a2, a;
    en = 1'b0;
    address(a1, a2);
    chk("R12 no ack disabled", {a1, a2}, 2'b00);
    send_byte(8'h24, a);
    chk("R12 no data ack", a, 0);
    chk("R12 no rx flag", rx_full, 0);
    bus_stop();
    chk("R12 no stop flag", stop_evt, 0);
    en = 1'b1;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic_write();
    t_bad_hi();
    t_bad_lo();
    t_nak_ctrl();
    t_restart();
    t_general_call();
    t_disabled();
    summary();
    $finish;
  end
endmodule